// File: doc/BRIEF.md
# Windowed Error Count Monitor

This block measures how many decoder errors occur. It counts one of three kinds of event each cycle: bit errors, where a single strobe can report several, byte errors, or uncorrectable packets. A type selector picks the kind. The running total is held in a 16-bit register. When the total reaches its maximum value it stops there and does not wrap.

Software launches a measurement by writing 1 to a start bit. This clears the count. In finite mode, the window is a number of received bytes. When the window's last byte has been counted, the hardware clears the start bit and the measurement ends. In unbounded mode, counting continues until software writes 0 to the start bit. After a measurement stops, the count keeps its final value until the next start.

Top module: `err_window_mon`

## Requirements
- R1: With `cnt_sel` = 0, each counting cycle adds `bit_err_num` to the count. Any value above 8 is treated as 8.
- R2: With `cnt_sel` = 1, each counting cycle in which `byte_err` is high adds 1 to the count.
- R3: With `cnt_sel` = 2, each counting cycle in which `pkt_err` is high adds 1. With `cnt_sel` = 3, nothing is counted.
- R4: The count saturates at 65535. This holds even when a single multi-error addition would overflow it, and the count then stays at 65535.
- R5: A write of 1 to the start bit clears the count and sets the start bit on the next edge. Errors presented in the cycle of the write are not counted. A start write takes priority over the self-clear at the end of a window.
- R6: In finite mode (`inf_mode` = 0), the window length is `win_len` byte strobes. Errors are counted up to and including the cycle of the last byte strobe, and the start bit then reads 0 on the next edge. A `win_len` of 0 behaves like 1.
- R7: In unbounded mode (`inf_mode` = 1), the start bit stays set however many bytes arrive.
- R8: A write of 0 to the start bit stops the measurement.
- R9: While the start bit is 0, the count holds its value whatever error inputs arrive.
- R10: After reset, the count is 0 and the start bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_sel | input | 2 | Selects what is counted: 0 bits, 1 bytes, 2 packets, 3 nothing |
| inf_mode | input | 1 | 1 selects unbounded counting, 0 selects a finite window |
| win_len | input | 16 | Finite window length in received bytes |
| start_wr | input | 1 | Write strobe for the start bit |
| start_wdata | input | 1 | Value written to the start bit |
| byte_vld | input | 1 | One received byte this cycle |
| bit_err_num | input | 4 | Number of bit errors this cycle |
| byte_err | input | 1 | Byte error this cycle |
| pkt_err | input | 1 | Uncorrectable packet this cycle |
| err_count | output | 16 | Measured error count |
| start_bit | output | 1 | Live value of the start bit |

## Verification
A table of finite-window runs drives every selector value. In each run the inactive error inputs are held high, so a wrong multiplexer choice shows up as an extra count. Runs shorter than the window are set against runs longer than it. This separates counting that stops at the window from counting that continues past it, and shows whether the start bit clears itself. Byte strobes with gaps show whether the window is measured in bytes or in cycles. A long unbounded run approaches 65535 and then crosses it with a partial addition, which tests saturation against wrap-around.

// File: rtl/err_window_mon.sv
module err_window_mon #(
  parameter int CNT_W   = 16,
  parameter int WIN_W   = 16,
  parameter int NUM_W   = 4,
  parameter int BIT_MAX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cnt_sel,
  input  logic             inf_mode,
  input  logic [WIN_W-1:0] win_len,
  input  logic             start_wr,
  input  logic             start_wdata,
  input  logic             byte_vld,
  input  logic [NUM_W-1:0] bit_err_num,
  input  logic             byte_err,
  input  logic             pkt_err,
  output logic [CNT_W-1:0] err_count,
  output logic             start_bit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [NUM_W-1:0] NUM_CAP = NUM_W'(BIT_MAX);

  logic [WIN_W-1:0] win_cnt;
  logic [NUM_W-1:0] bit_inc;
  logic [NUM_W-1:0] inc;
  logic [CNT_W:0]   sum;
  logic             win_end;

  assign bit_inc = (bit_err_num > NUM_CAP) ? NUM_CAP : bit_err_num;

  always_comb begin
    case (cnt_sel)
      2'd0:    inc = bit_inc;
      2'd1:    inc = NUM_W'(byte_err);
      2'd2:    inc = NUM_W'(pkt_err);
      default: inc = '0;
    endcase
  end

  assign sum     = {1'b0, err_count} + (CNT_W+1)'(inc);
  assign win_end = start_bit && !inf_mode && byte_vld &&
                   ({1'b0, win_cnt} + 1'b1 >= {1'b0, win_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_bit <= 1'b0;
      err_count <= '0;
      win_cnt   <= '0;
    end else if (start_wr) begin
      start_bit <= start_wdata;
      if (start_wdata) begin
        err_count <= '0;
        win_cnt   <= '0;
      end
    end else if (start_bit) begin
      err_count <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
      if (byte_vld) win_cnt <= win_cnt + 1'b1;
      if (win_end) start_bit <= 1'b0;
    end
  end

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && start_wdata |=> err_count == '0 && start_bit);

  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && !start_wdata |=> !start_bit);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_bit && !start_wr |=> err_count >= $past(err_count));

  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_bit && !start_wr && err_count == CNT_MAX |=> err_count == CNT_MAX);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_bit && !start_wr |=> $stable(err_count) && !start_bit);

  p_inf_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_bit && inf_mode && !start_wr |=> start_bit);

  p_null_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_bit && !start_wr && cnt_sel == 2'd3 |=> $stable(err_count));

endmodule

// File: tb/test_err_window_mon.sv
module test_err_window_mon;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cnt_sel = '0;
  logic        inf_mode = 1'b0;
  logic [15:0] win_len = '0;
  logic        start_wr = 1'b0;
  logic        start_wdata = 1'b0;
  logic        byte_vld = 1'b0;
  logic [3:0]  bit_err_num = '0;
  logic        byte_err = 1'b0;
  logic        pkt_err = 1'b0;
  logic [15:0] err_count;
  logic        start_bit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_window_mon i_err_window_mon (
    .clk(clk), .rst_n(rst_n), .cnt_sel(cnt_sel), .inf_mode(inf_mode),
    .win_len(win_len), .start_wr(start_wr), .start_wdata(start_wdata),
    .byte_vld(byte_vld), .bit_err_num(bit_err_num), .byte_err(byte_err),
    .pkt_err(pkt_err), .err_count(err_count), .start_bit(start_bit));

  typedef struct packed {
    logic [1:0]  sel;
    logic [7:0]  win;
    logic [3:0]  bitc;
    logic        be;
    logic        pe;
    logic [7:0]  cyc;
    logic [15:0] exp_cnt;
    logic        exp_st;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 8'd10, 4'd3,  1'b1, 1'b1, 8'd10, 16'd30, 1'b0},
    '{2'd0, 8'd10, 4'd3,  1'b1, 1'b1, 8'd4,  16'd12, 1'b1},
    '{2'd1, 8'd5,  4'd3,  1'b1, 1'b1, 8'd8,  16'd5,  1'b0},
    '{2'd2, 8'd7,  4'd2,  1'b1, 1'b1, 8'd7,  16'd7,  1'b0},
    '{2'd3, 8'd5,  4'd8,  1'b1, 1'b1, 8'd6,  16'd0,  1'b0},
    '{2'd0, 8'd4,  4'd12, 1'b1, 1'b1, 8'd4,  16'd32, 1'b0},
    '{2'd1, 8'd0,  4'd0,  1'b1, 1'b0, 8'd3,  16'd1,  1'b0},
    '{2'd0, 8'd6,  4'd0,  1'b1, 1'b1, 8'd6,  16'd0,  1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic bv, input logic [3:0] bn, input logic be, input logic pe);
    byte_vld = bv; bit_err_num = bn; byte_err = be; pkt_err = pe;
    @(negedge clk);
  endtask

  task automatic write_start(input logic v);
    start_wr = 1'b1; start_wdata = v;
    byte_vld = 1'b1; bit_err_num = 4'd5; byte_err = 1'b1; pkt_err = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    byte_vld = 1'b0; bit_err_num = '0; byte_err = 1'b0; pkt_err = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 count", err_count, 0);
    check("R10 start", start_bit, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5 R6 table of finite-window runs
    inf_mode = 1'b0;
    for (int v = 0; v < NV; v++) begin
      cnt_sel = TBL[v].sel;
      win_len = 16'(TBL[v].win);
      write_start(1'b1);
      check("R5 start set", start_bit, 1);
      check("R5 cleared", err_count, 0);
      for (int c = 0; c < int'(TBL[v].cyc); c++)
        step(1'b1, TBL[v].bitc, TBL[v].be, TBL[v].pe);
      step(1'b0, 4'd0, 1'b0, 1'b0);
      check("R1/R2/R3/R6 count", err_count, 32'(TBL[v].exp_cnt));
      check("R6 start after window", start_bit, 32'(TBL[v].exp_st));
    end

    // R6 window counts byte strobes, not cycles
    cnt_sel = 2'd1; win_len = 16'd3;
    write_start(1'b1);
    for (int c = 0; c < 6; c++) step(c % 2 == 1, 4'd0, 1'b1, 1'b0);
    check("R6 gapped bytes count", err_count, 6);
    check("R6 gapped bytes stop", start_bit, 0);
    for (int c = 0; c < 4; c++) step(1'b1, 4'd0, 1'b1, 1'b0);
    check("R9 hold after window", err_count, 6);

    // R5 start write beats window end
    cnt_sel = 2'd2; win_len = 16'd2;
    write_start(1'b1);
    step(1'b1, 4'd0, 1'b0, 1'b1);
    start_wr = 1'b1; start_wdata = 1'b1;
    step(1'b1, 4'd0, 1'b0, 1'b1);
    start_wr = 1'b0;
    check("R5 restart priority start", start_bit, 1);
    check("R5 restart priority count", err_count, 0);

    // R7 R4 unbounded run to saturation
    inf_mode = 1'b1; cnt_sel = 2'd0; win_len = 16'd1;
    write_start(1'b1);
    for (int c = 0; c < 8191; c++) step(1'b1, 4'd8, 1'b0, 1'b0);
    check("R7 still running", start_bit, 1);
    check("R4 near max", err_count, 65528);
    step(1'b1, 4'd7, 1'b0, 1'b0);
    check("R4 exact max", err_count, 65535);
    step(1'b1, 4'd5, 1'b0, 1'b0);
    check("R4 saturated", err_count, 65535);
    step(1'b1, 4'd8, 1'b0, 1'b0);
    check("R4 no wrap", err_count, 65535);

    // R8 R9 software stop then hold
    cnt_sel = 2'd1;
    write_start(1'b1);
    for (int c = 0; c < 5; c++) step(1'b1, 4'd0, 1'b1, 1'b0);
    check("R2 unbounded bytes", err_count, 5);
    write_start(1'b0);
    check("R8 stopped", start_bit, 0);
    check("R8 stop write no count", err_count, 5);
    for (int c = 0; c < 5; c++) step(1'b1, 4'd8, 1'b1, 1'b1);
    check("R9 held count", err_count, 5);
    check("R9 stays stopped", start_bit, 0);

    finish_run();
  end
endmodule